// File: doc/BRIEF.md
# External Interrupt Request Latch

This block takes one active-low external interrupt pin, brings it into the clock domain through a synchronizer, and captures requests in a single latch. The latch output, gated by a mask bit, forms the interrupt request presented to the processor. Alongside the request the block drives the fixed address of the vector the processor fetches when it services this source.

A mode bit chooses how the pin is sensed. In edge mode only a falling edge sets the latch, and any acknowledge clears it at once. In level mode a low level also sets and holds the latch. An acknowledge given while the pin is still low is remembered. The latch is then released on the first cycle the synchronized pin reads high. An acknowledge comes either from the processor's vector-fetch strobe or from software writing a one to the acknowledge bit of the control register. A falling edge always wins over an acknowledge in the same cycle.

The control register also reports the latch state and the synchronized pin level, so software can poll the pin without taking an interrupt.

Top module: `ext_irq_latch`

## Requirements
- R1: After reset, mode, mask and latch are 0, `irq_req_o` is 0, and with the pin idle high `reg_rdata` reads 0x10.
- R2: A falling edge on `irq_pin_n` sets the latch, visible in `reg_rdata` bit 3, three clock edges after the pin changes: two synchronizer stages, then the latch register.
- R3: With mode (bit 0) at 0, a `vec_ack_i` pulse or a register write with bit 2 set clears the latch on the next edge, even while the pin stays low. A low level alone does not set it again.
- R4: With mode at 1, an acknowledge while the synchronized pin is low leaves the latch set. The latch clears on the edge after the synchronized pin first reads high.
- R5: With mode at 1, a latch set by an edge stays set after the pin returns high until an acknowledge arrives, and then clears on the next edge.
- R6: With mode at 1, a low synchronized pin sets and holds the latch even without a falling edge, for example when the mode is switched on while the pin is low.
- R7: An acknowledge does not block later edges: a falling edge after an acknowledge sets the latch again. A falling edge and an acknowledge in the same cycle leave the latch set.
- R8: `irq_req_o` equals latch AND NOT mask, with the mask in register bit 1. The latch status bit is reported whatever the mask.
- R9: Register bit 2 is write-one-to-acknowledge and always reads 0. Writing 0 to it has no effect. Bit 3 is read-only. Bit 4 reads the synchronized pin level. Bits above 4 read 0.
- R10: `vec_addr_o` always presents the vector address 0xFFFA; the processor fetches the vector from bytes 0xFFFA and 0xFFFB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pin_n | input | 1 | Active-low external interrupt pin, asynchronous |
| vec_ack_i | input | 1 | One-cycle strobe from the processor when it fetches this vector |
| reg_wr_en | input | 1 | Write strobe for the control register |
| reg_wdata | input | 8 | Write data: bit 0 mode, bit 1 mask, bit 2 acknowledge |
| reg_rdata | output | 8 | Read data: bit 0 mode, bit 1 mask, bit 2 zero, bit 3 latch, bit 4 pin level |
| irq_req_o | output | 1 | Masked interrupt request to the processor |
| vec_addr_o | output | 16 | Address of the vector for this source |

## Verification
The assertions take for granted that the pin has been synchronized: they reason about the synchronized level and the edge strobe, never the raw pin, so metastability is outside their scope. They also assume the acknowledge and the edge strobe are both sampled on the same clock edge as the mode bit already in force, so a write that changes the mode acts only from the following cycle. The stimulus drives the pin, the strobe and the register writes only on falling clock edges. It holds each pin level for at least two cycles when a directed check depends on an edge being seen. It writes the mode only between requests, except in the one case that checks level sensing with the pin already low.

// File: rtl/irqlat_pkg.sv
package irqlat_pkg;

    // Control register field positions (decoded by software)
    localparam int unsigned BIT_MODE  = 0;
    localparam int unsigned BIT_MASK  = 1;
    localparam int unsigned BIT_ACK   = 2;
    localparam int unsigned BIT_LATCH = 3;
    localparam int unsigned BIT_PIN   = 4;
    localparam int unsigned REG_USED  = 5;

    typedef struct packed {
        logic latch;
        logic clr_pend;
    } core_state_t;

    typedef struct packed {
        logic mode;
        logic mask;
    } ctrl_state_t;

endpackage

// File: rtl/irqlat_sync.sv
module irqlat_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);

    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d    = chain_q;
        chain_d[0] = async_i;
        for (int i = 1; i < int'(STAGES); i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/irqlat_edge.sv
module irqlat_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic fall_o
);

    logic prev_d, prev_q;

    always_comb begin
        prev_d = level_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= prev_d;
    end

    assign fall_o = prev_q & ~level_i;

endmodule

// File: rtl/irqlat_core.sv
module irqlat_core
    import irqlat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin_s_i,
    input  logic fall_i,
    input  logic ack_i,
    input  logic level_mode_i,
    output logic latch_o
);

    core_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (fall_i) begin
            // a new edge outranks any acknowledge in the same cycle
            st_d.latch    = 1'b1;
            st_d.clr_pend = 1'b0;
        end else if (!level_mode_i) begin
            st_d.clr_pend = 1'b0;
            if (ack_i) st_d.latch = 1'b0;
        end else if (!pin_s_i) begin
            st_d.latch = 1'b1;
            if (ack_i) st_d.clr_pend = 1'b1;
        end else begin
            if (ack_i || st_q.clr_pend) st_d.latch = 1'b0;
            st_d.clr_pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign latch_o = st_q.latch;

    a_r2_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
        fall_i |=> st_q.latch);

    a_r3_edge_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (!level_mode_i && ack_i && !fall_i) |=> !st_q.latch);

    a_r6_low_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (level_mode_i && !pin_s_i) |=> st_q.latch);

    a_r4_release_high: assert property (@(posedge clk) disable iff (!rst_n)
        (level_mode_i && st_q.clr_pend && pin_s_i) |=> !st_q.latch);

    a_r4_pend_needs_latch: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.clr_pend |-> st_q.latch);

endmodule

// File: rtl/irqlat_regs.sv
module irqlat_regs
    import irqlat_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              latch_i,
    input  logic              pin_s_i,
    output logic              mode_o,
    output logic              mask_o,
    output logic              sw_ack_o,
    output logic [DATA_W-1:0] rdata_o
);

    ctrl_state_t ctl_d, ctl_q;
    logic        unused_hi;

    assign unused_hi = ^wdata_i[DATA_W-1:BIT_LATCH];

    always_comb begin
        ctl_d = ctl_q;
        if (wr_en_i) begin
            ctl_d.mode = wdata_i[BIT_MODE];
            ctl_d.mask = wdata_i[BIT_MASK];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign sw_ack_o = wr_en_i & wdata_i[BIT_ACK];
    assign mode_o   = ctl_q.mode;
    assign mask_o   = ctl_q.mask;

    always_comb begin
        rdata_o            = '0;
        rdata_o[BIT_MODE]  = ctl_q.mode;
        rdata_o[BIT_MASK]  = ctl_q.mask;
        rdata_o[BIT_LATCH] = latch_i;
        rdata_o[BIT_PIN]   = pin_s_i;
    end

    a_r9_write_takes_mode: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> (mode_o == $past(wdata_i[BIT_MODE])) && (mask_o == $past(wdata_i[BIT_MASK])));

    a_r9_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(mode_o) && $stable(mask_o));

endmodule

// File: rtl/ext_irq_latch.sv
module ext_irq_latch
    import irqlat_pkg::*;
#(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned ADDR_W      = 16,
    parameter logic [ADDR_W-1:0] VEC_ADDR = 16'hFFFA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_pin_n,
    input  logic              vec_ack_i,
    input  logic              reg_wr_en,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_req_o,
    output logic [ADDR_W-1:0] vec_addr_o
);

    logic pin_s, fall, latch, mode, mask, sw_ack, ack;

    irqlat_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(irq_pin_n), .sync_o(pin_s)
    );

    irqlat_edge u_edge (
        .clk(clk), .rst_n(rst_n), .level_i(pin_s), .fall_o(fall)
    );

    irqlat_regs #(.DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en_i(reg_wr_en), .wdata_i(reg_wdata),
        .latch_i(latch), .pin_s_i(pin_s), .mode_o(mode), .mask_o(mask),
        .sw_ack_o(sw_ack), .rdata_o(reg_rdata)
    );

    assign ack = vec_ack_i | sw_ack;

    irqlat_core u_core (
        .clk(clk), .rst_n(rst_n), .pin_s_i(pin_s), .fall_i(fall),
        .ack_i(ack), .level_mode_i(mode), .latch_o(latch)
    );

    assign irq_req_o  = latch & ~mask;
    assign vec_addr_o = VEC_ADDR;

    a_r8_req_implies_pending: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req_o |-> reg_rdata[BIT_LATCH]);

    a_r9_ack_bit_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> !reg_rdata[BIT_ACK]);

endmodule

// File: tb/ext_irq_latch_tb.sv
`timescale 1ns/100ps
module ext_irq_latch_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       irq_pin_n = 1'b1;
    logic       vec_ack_i = 1'b0;
    logic       reg_wr_en = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq_req_o;
    logic [15:0] vec_addr_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ext_irq_latch u_dut (
        .clk(clk), .rst_n(rst_n), .irq_pin_n(irq_pin_n), .vec_ack_i(vec_ack_i),
        .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_req_o(irq_req_o), .vec_addr_o(vec_addr_o)
    );

    // Behavioural reference: pin history, a pending flag and an owed release
    bit p1, p2, pold, m_pend, m_owed, m_mode, m_mask;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p1 = 1; p2 = 1; pold = 1;
            m_pend = 0; m_owed = 0; m_mode = 0; m_mask = 0;
        end else begin
            bit went_low, acked;
            went_low = pold && !p2;
            acked    = vec_ack_i || (reg_wr_en && reg_wdata[2]);
            if (went_low) begin
                m_pend = 1; m_owed = 0;
            end else if (m_mode == 0) begin
                m_owed = 0;
                if (acked) m_pend = 0;
            end else if (p2 == 0) begin
                m_pend = 1;
                if (acked) m_owed = 1;
            end else begin
                if (acked || m_owed) m_pend = 0;
                m_owed = 0;
            end
            pold = p2; p2 = p1; p1 = irq_pin_n;
            if (reg_wr_en) begin
                m_mode = reg_wdata[0];
                m_mask = reg_wdata[1];
            end
        end
    end

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R8 model irq_req", {15'd0, irq_req_o}, {15'd0, m_pend && !m_mask});
            check("R9 model register", {8'd0, reg_rdata},
                  {8'd0, 3'b000, p2, m_pend, 1'b0, m_mask, m_mode});
        end
    end

    task automatic tick(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic wr(logic [7:0] v);
        reg_wr_en = 1'b1; reg_wdata = v;
        tick(1);
        reg_wr_en = 1'b0; reg_wdata = 8'h00;
    endtask

    task automatic vack();
        vec_ack_i = 1'b1;
        tick(1);
        vec_ack_i = 1'b0;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        check("R1 reset register", reg_rdata, 8'h10);
        check("R1 reset request", irq_req_o, 1'b0);
        check("R10 vector address", vec_addr_o, 16'hFFFA);

        // R2: edge through synchronizer, three edges to the latch
        irq_pin_n = 1'b0;
        tick(2);
        check("R2 latch not yet set", reg_rdata[3], 1'b0);
        tick(1);
        check("R2 latch set by edge", reg_rdata[3], 1'b1);
        check("R8 unmasked request", irq_req_o, 1'b1);
        check("R9 pin level low", reg_rdata[4], 1'b0);

        // R3: edge mode, vector fetch clears while pin low
        vack();
        check("R3 cleared by vector ack", reg_rdata[3], 1'b0);
        tick(4);
        check("R3 low level ignored in edge mode", reg_rdata[3], 1'b0);

        // R7: edge after ack latches again; edge beats simultaneous ack
        irq_pin_n = 1'b1; tick(3);
        irq_pin_n = 1'b0; tick(3);
        check("R7 re-latched after ack", reg_rdata[3], 1'b1);
        wr(8'h04);
        check("R3 cleared by software ack", reg_rdata[3], 1'b0);
        irq_pin_n = 1'b1; tick(3);
        irq_pin_n = 1'b0; tick(2);
        vack();
        check("R7 edge wins over ack", reg_rdata[3], 1'b1);
        wr(8'h04);
        irq_pin_n = 1'b1; tick(3);

        // R4: level mode, ack while low, release when high
        wr(8'h01);
        irq_pin_n = 1'b0; tick(3);
        check("R4 latched in level mode", reg_rdata[3], 1'b1);
        wr(8'h05);
        tick(2);
        check("R4 ack while low keeps latch", reg_rdata[3], 1'b1);
        irq_pin_n = 1'b1; tick(2);
        check("R4 still set before release", reg_rdata[3], 1'b1);
        tick(1);
        check("R4 released on pin high", reg_rdata[3], 1'b0);

        // R5: pin back high first, then ack
        irq_pin_n = 1'b0; tick(3);
        irq_pin_n = 1'b1; tick(5);
        check("R5 held without ack", reg_rdata[3], 1'b1);
        vack();
        check("R5 cleared by ack after pin high", reg_rdata[3], 1'b0);

        // R6: level sensing without an edge
        wr(8'h00);
        irq_pin_n = 1'b0; tick(3);
        wr(8'h04);
        check("R6 edge mode cleared while low", reg_rdata[3], 1'b0);
        wr(8'h01);
        tick(1);
        check("R6 low level sets latch", reg_rdata[3], 1'b1);
        irq_pin_n = 1'b1; tick(3);
        wr(8'h05);
        check("R6 cleared after high and ack", reg_rdata[3], 1'b0);

        // R8: mask gates request but not status
        wr(8'h03);
        irq_pin_n = 1'b0; tick(3);
        check("R8 status with mask", reg_rdata[3], 1'b1);
        check("R8 masked request", irq_req_o, 1'b0);
        wr(8'h01);
        check("R8 unmasked again", irq_req_o, 1'b1);
        irq_pin_n = 1'b1; tick(3);
        wr(8'h05);

        // R9: read-only latch, ack bit reads zero, zero ack ignored
        wr(8'h00);
        irq_pin_n = 1'b0; tick(3);
        wr(8'hF8);
        check("R9 latch read-only, ack reads 0", reg_rdata, 8'h08);
        tick(2);
        check("R9 zero ack leaves latch", reg_rdata[3], 1'b1);
        irq_pin_n = 1'b1; tick(2);
        check("R9 pin level high", reg_rdata[4], 1'b1);

        tick(2);
        done = 1'b1;
        summary();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

endmodule